// File: doc/BRIEF.md
# DDR2 command decoder with bank tracker

This block sits on the command side of a DDR2-style memory device model. On every rising clock edge where clock enable is high it samples the four active-low command pins, the two bank-select bits and the 13-bit address bus. It turns each sample into exactly one registered, single-cycle command strobe. The strobes are activate, precharge, read, write, mode-register set, refresh and no-operation. The sampled bank and address are registered next to the strobe, so downstream logic sees the command and its operands in the same cycle.

For each of the four banks the block keeps an open/idle flag and the row that was opened. A read or write to an idle bank, or an activate to a bank that is already open, is reported on a one-cycle illegal flag and changes nothing. A read or write with address bit 10 set also raises an auto-precharge flag. It closes its bank after a programmable number of clock-enabled edges. While clock enable is sampled low, no strobe is produced and all bank state, including the auto-precharge countdowns, holds.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: When `cs_n` is high at an enabled edge, only `nop_stb` pulses and no bank changes because of the pins.
- R2: `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=1 pulses `act_stb`; if the bank chosen by `ba` is idle it opens and stores `addr[12:0]` as its row in `open_rows[ba*13 +: 13]`.
- R3: `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0 pulses `pre_stb` and leaves bank `ba` idle, cancelling any pending auto-precharge on it.
- R4: `cs_n`=0, `ras_n`=1, `cas_n`=0 pulses `rd_stb` when `we_n`=1 and `wr_stb` when `we_n`=0; `cmd_bank` carries `ba` and `col_addr` carries `addr[8:0]`.
- R5: A read or write with `addr[10]`=1 pulses `autopre`. On an open bank it closes that bank at the N-th enabled edge after the command, where N is `ap_delay` and a value of 0 counts as 1.
- R6: All of `ras_n`, `cas_n`, `we_n` low pulses `mrs_stb`. `ras_n`=0, `cas_n`=0, `we_n`=1 pulses `ref_stb`. `ras_n`=1, `cas_n`=1 pulses `nop_stb`. Exactly one strobe is high after each enabled edge.
- R7: A read or write to an idle bank, or an activate to an open bank, pulses `illegal` for one cycle. The command strobe still pulses, but no bank open flag or stored row changes and no auto-precharge is armed.
- R8: At an edge where `cke` is low, all strobes, `autopre` and `illegal` are low for the next cycle. Bank flags, rows and countdowns hold.
- R9: If a countdown expires at the same edge as a command to that bank, the command is judged against the bank still open. A read or write with `addr[10]`=1 re-arms the countdown and keeps the bank open. Any other command lets the bank close, and an activate there is illegal.
- R10: During reset all strobes, `autopre`, `illegal` and `bank_open` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low freezes the block |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row/column address; bit 10 requests auto-precharge |
| ap_delay | input | 4 | Auto-precharge countdown length in enabled edges |
| act_stb | output | 1 | Activate decoded |
| pre_stb | output | 1 | Precharge decoded |
| rd_stb | output | 1 | Read decoded |
| wr_stb | output | 1 | Write decoded |
| mrs_stb | output | 1 | Mode-register set decoded |
| ref_stb | output | 1 | Refresh decoded |
| nop_stb | output | 1 | No-operation decoded (also masked commands) |
| cmd_bank | output | 2 | Bank of the last enabled sample |
| row_addr | output | 13 | Address of the last enabled sample |
| col_addr | output | 9 | Column part of that address |
| autopre | output | 1 | Read/write with auto-precharge request |
| illegal | output | 1 | Access to idle bank or activate to open bank |
| bank_open | output | 4 | Open flag per bank |
| open_rows | output | 52 | Stored row per bank, bank i at bits i*13 +: 13 |

## Verification
The auto-precharge countdown of a bank and an explicit command from the pins to that same bank can land on the same edge. The bench provokes this by setting `ap_delay` to 2 and issuing a read two edges after an auto-precharge read. It does this once without bit 10, where the bank must close, and once with it, where the bank must stay open for two more edges. A behavioural per-bank model, built with the collision rule of R9, is compared with every output on each clock. Long runs with random pins, masked selects and clock-enable gaps then bring further collisions, including illegal activates at the expiry edge.

// File: rtl/ddr2cd_pkg.sv
package ddr2cd_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_PRE = 3'd2,
      CMD_RD  = 3'd3,
      CMD_WR  = 3'd4,
      CMD_MRS = 3'd5,
      CMD_REF = 3'd6
   } cmd_e;
endpackage

// File: rtl/ddr2cd_decode.sv
module ddr2cd_decode
   import ddr2cd_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);
   always_comb begin
      cmd = CMD_NOP;
      if (!cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b010:  cmd = CMD_PRE;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b000:  cmd = CMD_MRS;
            3'b001:  cmd = CMD_REF;
            default: cmd = CMD_NOP;
         endcase
      end
   end
endmodule

// File: rtl/ddr2cd_bank.sv
module ddr2cd_bank
   import ddr2cd_pkg::*;
#(
   parameter int ROW_W = 13,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             hit,
   input  cmd_e             cmd,
   input  logic             ap_req,
   input  logic [ROW_W-1:0] row_in,
   input  logic [CNT_W-1:0] dly,
   output logic             is_open,
   output logic [ROW_W-1:0] row_q
);
   logic             pend;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] dly_eff;
   logic             expire;
   logic             col_cmd;

   assign dly_eff = (dly == '0) ? CNT_W'(1) : dly;
   assign expire  = pend && (cnt == CNT_W'(1));
   assign col_cmd = (cmd == CMD_RD) || (cmd == CMD_WR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         row_q   <= '0;
         pend    <= 1'b0;
         cnt     <= '0;
      end else if (en) begin
         if (hit && cmd == CMD_ACT && !is_open) begin
            is_open <= 1'b1;
            row_q   <= row_in;
         end else if (hit && cmd == CMD_PRE) begin
            is_open <= 1'b0;
            pend    <= 1'b0;
         end else if (hit && col_cmd && ap_req && is_open) begin
            pend <= 1'b1;
            cnt  <= dly_eff;
         end else if (expire) begin
            is_open <= 1'b0;
            pend    <= 1'b0;
         end else if (pend) begin
            cnt <= cnt - CNT_W'(1);
         end
      end
   end

   // R5: a pending countdown only exists on an open bank
   p_pend_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> is_open);
   p_pre_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && hit && cmd == CMD_PRE) |=> !is_open);
   p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && hit && cmd == CMD_ACT && !is_open) |=> (is_open && row_q == $past(row_in)));
   p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(is_open) && $stable(cnt) && $stable(pend)));
endmodule

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker
   import ddr2cd_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int ADDR_W = 13,
   parameter int COL_W  = 9,
   parameter int AP_BIT = 10,
   parameter int CNT_W  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cke,
   input  logic                      cs_n,
   input  logic                      ras_n,
   input  logic                      cas_n,
   input  logic                      we_n,
   input  logic [BANK_W-1:0]         ba,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [CNT_W-1:0]          ap_delay,
   output logic                      act_stb,
   output logic                      pre_stb,
   output logic                      rd_stb,
   output logic                      wr_stb,
   output logic                      mrs_stb,
   output logic                      ref_stb,
   output logic                      nop_stb,
   output logic [BANK_W-1:0]         cmd_bank,
   output logic [ADDR_W-1:0]         row_addr,
   output logic [COL_W-1:0]          col_addr,
   output logic                      autopre,
   output logic                      illegal,
   output logic [(1<<BANK_W)-1:0]    bank_open,
   output logic [(1<<BANK_W)*ADDR_W-1:0] open_rows
);
   localparam int NBANK = 1 << BANK_W;

   if (AP_BIT >= ADDR_W || COL_W > AP_BIT || CNT_W < 1 || BANK_W < 1) begin : g_bad_cfg
      $error("ddr2_cmd_tracker: inconsistent address, column or counter widths");
   end

   cmd_e dec_cmd;
   logic sel_open;
   logic col_cmd;
   logic ap_req;
   logic illegal_now;

   ddr2cd_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (dec_cmd)
   );

   assign sel_open    = bank_open[ba];
   assign col_cmd     = (dec_cmd == CMD_RD) || (dec_cmd == CMD_WR);
   assign ap_req      = col_cmd && addr[AP_BIT];
   assign illegal_now = (col_cmd && !sel_open) || (dec_cmd == CMD_ACT && sel_open);

   for (genvar i = 0; i < NBANK; i++) begin : g_bank
      ddr2cd_bank #(.ROW_W(ADDR_W), .CNT_W(CNT_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (cke),
         .hit     (ba == BANK_W'(i)),
         .cmd     (dec_cmd),
         .ap_req  (ap_req),
         .row_in  (addr),
         .dly     (ap_delay),
         .is_open (bank_open[i]),
         .row_q   (open_rows[i*ADDR_W +: ADDR_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         {act_stb, pre_stb, rd_stb, wr_stb, mrs_stb, ref_stb, nop_stb} <= '0;
         autopre  <= 1'b0;
         illegal  <= 1'b0;
         cmd_bank <= '0;
         row_addr <= '0;
      end else if (cke) begin
         act_stb  <= (dec_cmd == CMD_ACT);
         pre_stb  <= (dec_cmd == CMD_PRE);
         rd_stb   <= (dec_cmd == CMD_RD);
         wr_stb   <= (dec_cmd == CMD_WR);
         mrs_stb  <= (dec_cmd == CMD_MRS);
         ref_stb  <= (dec_cmd == CMD_REF);
         nop_stb  <= (dec_cmd == CMD_NOP);
         autopre  <= ap_req;
         illegal  <= illegal_now;
         cmd_bank <= ba;
         row_addr <= addr;
      end else begin
         {act_stb, pre_stb, rd_stb, wr_stb, mrs_stb, ref_stb, nop_stb} <= '0;
         autopre <= 1'b0;
         illegal <= 1'b0;
      end
   end

   assign col_addr = row_addr[COL_W-1:0];

   // R6: one strobe per enabled edge
   p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> ($countones({act_stb, pre_stb, rd_stb, wr_stb, mrs_stb, ref_stb, nop_stb}) == 1));
   p_gated_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> ({act_stb, pre_stb, rd_stb, wr_stb, mrs_stb, ref_stb, nop_stb, autopre, illegal} == '0));
   p_cs_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && cs_n) |=> nop_stb);
   p_illegal_keeps_rows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && illegal_now) |=> $stable(open_rows));
endmodule

// File: tb/ddr2_cmd_tracker_tb_top.sv
module ddr2_cmd_tracker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke = 1'b1;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;
   logic [3:0]  ap_delay = 4'd4;
   logic act_stb, pre_stb, rd_stb, wr_stb, mrs_stb, ref_stb, nop_stb;
   logic [1:0]  cmd_bank;
   logic [12:0] row_addr;
   logic [8:0]  col_addr;
   logic        autopre, illegal;
   logic [3:0]  bank_open;
   logic [51:0] open_rows;

   int nchk = 0, nerr = 0;
   bit cmp_en = 0, done = 0;

   // reference model state
   bit        m_open [4];
   bit [12:0] m_row  [4];
   bit        m_pend [4];
   int        m_cnt  [4];
   bit [6:0]  e_stb = '0;
   bit [1:0]  e_bank = '0;
   bit [12:0] e_addr = '0;
   bit        e_ap = 0, e_ill = 0;

   ddr2_cmd_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .ap_delay(ap_delay),
      .act_stb(act_stb), .pre_stb(pre_stb), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .mrs_stb(mrs_stb), .ref_stb(ref_stb), .nop_stb(nop_stb),
      .cmd_bank(cmd_bank), .row_addr(row_addr), .col_addr(col_addr),
      .autopre(autopre), .illegal(illegal), .bank_open(bank_open),
      .open_rows(open_rows)
   );

   always #5 clk = ~clk;

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   // code: 0 nop, 1 act, 2 pre, 3 rd, 4 wr, 5 mrs, 6 ref
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < 4; b++) begin
            m_open[b] = 0; m_row[b] = '0; m_pend[b] = 0; m_cnt[b] = 0;
         end
         e_stb = '0; e_bank = '0; e_addr = '0; e_ap = 0; e_ill = 0;
      end else if (cke) begin
         int  c;
         bit  col;
         c = 0;
         if (!cs_n) begin
            if (!ras_n && cas_n && we_n)        c = 1;
            else if (!ras_n && cas_n && !we_n)  c = 2;
            else if (ras_n && !cas_n && we_n)   c = 3;
            else if (ras_n && !cas_n && !we_n)  c = 4;
            else if (!ras_n && !cas_n && !we_n) c = 5;
            else if (!ras_n && !cas_n && we_n)  c = 6;
         end
         col    = (c == 3) || (c == 4);
         e_stb  = 7'(1) << c;
         e_bank = ba;
         e_addr = addr;
         e_ap   = col && addr[10];
         e_ill  = (col && !m_open[ba]) || (c == 1 && m_open[ba]);
         for (int b = 0; b < 4; b++) begin
            bit hit;
            hit = (int'(ba) == b);
            if (hit && c == 1 && !m_open[b]) begin
               m_open[b] = 1; m_row[b] = addr;
            end else if (hit && c == 2) begin
               m_open[b] = 0; m_pend[b] = 0;
            end else if (hit && col && m_open[b] && addr[10]) begin
               m_pend[b] = 1; m_cnt[b] = (ap_delay == 0) ? 1 : int'(ap_delay);
            end else if (m_pend[b] && m_cnt[b] == 1) begin
               m_open[b] = 0; m_pend[b] = 0;
            end else if (m_pend[b]) begin
               m_cnt[b]--;
            end
         end
      end else begin
         e_stb = '0; e_ap = 0; e_ill = 0;
      end
   end

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         chk("R6 nop_stb", nop_stb, e_stb[0]);
         chk("R2 act_stb", act_stb, e_stb[1]);
         chk("R3 pre_stb", pre_stb, e_stb[2]);
         chk("R4 rd_stb",  rd_stb,  e_stb[3]);
         chk("R4 wr_stb",  wr_stb,  e_stb[4]);
         chk("R6 mrs_stb", mrs_stb, e_stb[5]);
         chk("R6 ref_stb", ref_stb, e_stb[6]);
         chk("R4 cmd_bank", cmd_bank, e_bank);
         chk("R4 row_addr", row_addr, e_addr);
         chk("R4 col_addr", col_addr, e_addr[8:0]);
         chk("R5 autopre", autopre, e_ap);
         chk("R7 illegal", illegal, e_ill);
         for (int b = 0; b < 4; b++) begin
            chk("R5 bank_open", bank_open[b], m_open[b]);
            chk("R2 open_rows", open_rows[b*13 +: 13], m_row[b]);
         end
      end
   end

   task automatic step(input logic k, input logic c, input logic r, input logic ca,
                       input logic w, input logic [1:0] b, input logic [12:0] a);
      cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
      @(negedge clk);
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1, 0, 1, 1, 1, 2'd0, 13'd0);
   endtask
   task automatic act(input logic [1:0] b, input logic [12:0] row);
      step(1, 0, 0, 1, 1, b, row);
   endtask
   task automatic pre(input logic [1:0] b);
      step(1, 0, 0, 1, 0, b, 13'd0);
   endtask
   task automatic rd(input logic [1:0] b, input logic [8:0] col, input logic ap);
      step(1, 0, 1, 0, 1, b, {2'b00, ap, 1'b0, col});
   endtask
   task automatic wr(input logic [1:0] b, input logic [8:0] col, input logic ap);
      step(1, 0, 1, 0, 0, b, {2'b00, ap, 1'b0, col});
   endtask

   task automatic finish_run;
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 strobes", {act_stb, pre_stb, rd_stb, wr_stb, mrs_stb, ref_stb, nop_stb}, 0);
      chk("R10 flags", {autopre, illegal}, 0);
      chk("R10 bank_open", bank_open, 0);
      rst_n = 1'b1;
      cmp_en = 1;
      idle(1);
      chk("R6 nop after idle", nop_stb, 1);

      act(2'd1, 13'h1ABC);
      chk("R2 act strobe", act_stb, 1);
      chk("R2 bank1 open", bank_open, 4'b0010);
      chk("R2 bank1 row", open_rows[13 +: 13], 13'h1ABC);

      step(1, 1, 0, 1, 1, 2'd2, 13'h0055);
      chk("R1 masked act is nop", {act_stb, nop_stb}, 2'b01);
      chk("R1 bank2 unchanged", bank_open, 4'b0010);

      rd(2'd1, 9'h155, 1'b0);
      chk("R4 read strobe", rd_stb, 1);
      chk("R4 column", col_addr, 9'h155);
      chk("R4 bank", cmd_bank, 2'd1);
      chk("R5 no autopre", autopre, 0);

      wr(2'd3, 9'h00F, 1'b0);
      chk("R7 write to idle flagged", {wr_stb, illegal}, 2'b11);
      chk("R7 state unchanged", bank_open, 4'b0010);

      act(2'd1, 13'h0777);
      chk("R7 act on open flagged", {act_stb, illegal}, 2'b11);
      chk("R7 row kept", open_rows[13 +: 13], 13'h1ABC);
      idle(1);
      chk("R7 one-cycle flag", illegal, 0);

      step(1, 0, 0, 0, 0, 2'd0, 13'h0042);
      chk("R6 mode set", mrs_stb, 1);
      step(1, 0, 0, 0, 1, 2'd0, 13'h0000);
      chk("R6 refresh", ref_stb, 1);
      step(1, 0, 1, 1, 0, 2'd0, 13'h0000);
      chk("R6 leftover code is nop", nop_stb, 1);

      step(0, 0, 0, 1, 1, 2'd0, 13'h0123);
      chk("R8 gated: no strobe", {act_stb, pre_stb, rd_stb, wr_stb, mrs_stb, ref_stb, nop_stb}, 0);
      chk("R8 gated: bank0 idle", bank_open, 4'b0010);

      pre(2'd1);
      chk("R3 precharge", {pre_stb, bank_open}, {1'b1, 4'b0000});

      // R5: countdown of 3 with a frozen edge in between
      ap_delay = 4'd3;
      act(2'd0, 13'h0A0A);
      wr(2'd0, 9'h011, 1'b1);
      chk("R5 autopre flag", {wr_stb, autopre, illegal}, 3'b110);
      idle(1);
      chk("R5 open after 1", bank_open[0], 1);
      step(0, 0, 1, 1, 1, 2'd0, 13'd0);
      chk("R8 countdown frozen", bank_open[0], 1);
      idle(1);
      chk("R5 open after 2", bank_open[0], 1);
      idle(1);
      chk("R5 closed after 3", bank_open[0], 0);

      // R5: delay 0 counts as 1
      ap_delay = 4'd0;
      act(2'd2, 13'h0003);
      rd(2'd2, 9'h001, 1'b1);
      chk("R5 zero delay open", bank_open[2], 1);
      idle(1);
      chk("R5 zero delay closed", bank_open[2], 0);

      // R9: command meeting an expiring countdown
      ap_delay = 4'd2;
      act(2'd0, 13'h0100);
      rd(2'd0, 9'h002, 1'b1);
      idle(1);
      rd(2'd0, 9'h003, 1'b0);
      chk("R9 plain read at expiry: legal", illegal, 0);
      chk("R9 plain read at expiry: closes", bank_open[0], 0);
      act(2'd0, 13'h0200);
      rd(2'd0, 9'h004, 1'b1);
      idle(1);
      rd(2'd0, 9'h005, 1'b1);
      chk("R9 re-armed stays open", bank_open[0], 1);
      idle(1);
      chk("R9 re-armed open", bank_open[0], 1);
      idle(1);
      chk("R9 re-armed closes", bank_open[0], 0);
      act(2'd3, 13'h0300);
      rd(2'd3, 9'h006, 1'b1);
      idle(1);
      act(2'd3, 13'h0400);
      chk("R9 act at expiry illegal", illegal, 1);
      chk("R9 act at expiry closes", bank_open[3], 0);

      // random phase, compared against the model on every clock
      for (int i = 0; i < 6000; i++) begin
         if ($urandom % 50 == 0) ap_delay = 4'($urandom % 6);
         step(($urandom % 10) != 0, ($urandom % 10) == 0,
              1'($urandom), 1'($urandom), 1'($urandom),
              2'($urandom), 13'($urandom));
      end
      idle(2);
      finish_run();
   end
endmodule